// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Limiter

This block sits between the PWM modulator of a fixed-frequency buck converter and the gate driver of its power switch. Each switching period opens with a one-cycle strobe. If the modulator requests on-time at that strobe and no skip is pending, the switch turns on. It stays on for as long as the request holds, unless the overcurrent comparator ends the pulse early. All timing runs on a fast system clock.

Switching noise makes the comparator unreliable at the start of each on-time, so its flag is ignored for a fixed number of system clock cycles after turn-on. The flag is sampled once, in the last cycle of that window, and the sample labels the pulse as faulted or clean. A faulted pulse ends at once. It also raises an adaptive skip level by one, up to seven, and the block then leaves out that many following turn-ons. A clean pulse lowers the level by one. Under sustained overload the switch therefore fires only once every eight periods. A flag that rises after the window still ends the pulse, but it does not change the level.

Top module: `ocl_pulse_limiter`

## Requirements
- R1: While `rst_ni` is low, `gate_en_o` is 0 and `skip_cnt_o` is 0.
- R2: A `period_start_i` strobe that sees `pwm_req_i` high, with no skip pending, raises `gate_en_o` from the next cycle. `gate_en_o` falls the cycle after `pwm_req_i` is seen low.
- R3: For the first `BLANK_CYC` cycles of an on-time, `oc_flag_i` has no effect. `gate_en_o` stays high and the pulse counts as clean if the flag is low in the last of those cycles.
- R4: If `oc_flag_i` is high in the last blanking cycle (the `BLANK_CYC`-th clock after the turn-on strobe), `gate_en_o` is low from the next cycle until the next turn-on.
- R5: A faulted pulse raises the skip level by one. The level becomes that new value N, and the next N period strobes produce no turn-on.
- R6: The skip level saturates at 7. Under an overcurrent that never clears, exactly one turn-on occurs in every 8 periods.
- R7: A clean pulse lowers the skip level by one. The level does not go below 0.
- R8: An `oc_flag_i` that rises after blanking ends the pulse the next cycle, and the skip level is unchanged.
- R9: A pulse whose request ends before blanking completes is neither faulted nor clean, and the skip level is unchanged.
- R10: `skip_cnt_o` always shows the current skip level, from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | One-cycle strobe at the start of each switching period |
| pwm_req_i | input | 1 | On-time request from the modulator |
| oc_flag_i | input | 1 | Overcurrent comparator output |
| gate_en_o | output | 1 | Power switch gate enable |
| skip_cnt_o | output | SKIP_W | Current skip level |

## Verification
Periods are driven with five overcurrent shapes, and each shape separates one behaviour from the others:
- A flag that stays low everywhere, or is high only inside blanking, must look identical to each other: the pulse is full length and the level falls.
- A flag held high through the whole period drives the level up, one step per fault, until it saturates. The count of turn-ons over 24 periods then shows the 1-in-8 rate.
- A flag that rises only after blanking must cut the pulse while still counting it as clean.
- A request that ends before blanking must leave the level untouched even with the flag high.

A behavioural model in the bench checks gate and level on every clock.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_CLEAN = 2'd1,
    EV_FAULT = 2'd2
  } blank_ev_e;
endpackage

// File: rtl/ocl_blank_timer.sv
module ocl_blank_timer #(
  parameter int BLANK_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o,
  output logic end_o
);
  localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign end_o    = active_q && (cnt_q == LAST);

  // R3
  window_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !end_o && !start_i && !abort_i |=> active_q);
endmodule

// File: rtl/ocl_skip_ctrl.sv
module ocl_skip_ctrl
  import ocl_pkg::*;
#(
  parameter int SKIP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  blank_ev_e         ev_i,
  input  logic              consume_i,
  output logic [SKIP_W-1:0] level_o,
  output logic              pending_o
);
  localparam logic [SKIP_W-1:0] LVL_MAX = {SKIP_W{1'b1}};

  logic [SKIP_W-1:0] level_q, left_q, lvl_up;

  assign lvl_up = (level_q == LVL_MAX) ? LVL_MAX : level_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      left_q  <= '0;
    end else begin
      if (ev_i == EV_FAULT) begin
        level_q <= lvl_up;
        left_q  <= lvl_up;
      end else begin
        if (ev_i == EV_CLEAN && level_q != '0) level_q <= level_q - 1'b1;
        if (consume_i && left_q != '0)         left_q  <= left_q - 1'b1;
      end
    end
  end

  assign level_o   = level_q;
  assign pending_o = (left_q != '0);

  // R5
  fault_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_FAULT && level_q != LVL_MAX |=> level_q == $past(level_q) + 1'b1);
  // R5
  skip_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_FAULT |=> pending_o);
  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_FAULT && level_q == LVL_MAX |=> level_q == LVL_MAX);
  // R7
  clean_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_CLEAN && level_q != '0 |=> level_q == $past(level_q) - 1'b1);
endmodule

// File: rtl/ocl_pulse_limiter.sv
module ocl_pulse_limiter
  import ocl_pkg::*;
#(
  parameter int BLANK_CYC = 20,
  parameter int SKIP_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              period_start_i,
  input  logic              pwm_req_i,
  input  logic              oc_flag_i,
  output logic              gate_en_o,
  output logic [SKIP_W-1:0] skip_cnt_o
);
  logic      on_q;
  logic      pending, blanking, blank_end;
  logic      pulse_start, consume, eval, late_cut;
  blank_ev_e ev;

  assign pulse_start = period_start_i && !pending && pwm_req_i;
  assign consume     = period_start_i && pending;
  // one sample of the flag, at the last blanking cycle of a live pulse
  assign eval        = on_q && pwm_req_i && !period_start_i && blank_end;
  assign ev          = !eval ? EV_NONE : (oc_flag_i ? EV_FAULT : EV_CLEAN);
  assign late_cut    = on_q && !blanking && oc_flag_i;

  ocl_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (pulse_start),
    .abort_i  (!pwm_req_i || consume),
    .active_o (blanking),
    .end_o    (blank_end)
  );

  ocl_skip_ctrl #(.SKIP_W(SKIP_W)) i_skip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .consume_i (consume),
    .level_o   (skip_cnt_o),
    .pending_o (pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  on_q <= 1'b0;
    else if (pulse_start)                         on_q <= 1'b1;
    else if (period_start_i || !pwm_req_i ||
             ev == EV_FAULT || late_cut)          on_q <= 1'b0;
  end

  assign gate_en_o = on_q;

  // R2
  start_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i && pwm_req_i && !pending |=> gate_en_o);
  // R3
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q && blanking && !blank_end && pwm_req_i && !period_start_i |=> gate_en_o);
  // R4
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_end && on_q && pwm_req_i && !period_start_i && oc_flag_i |=> !gate_en_o);
  // R5
  skip_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i && pending |=> !gate_en_o);
  // R8
  late_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_cut |=> $stable(skip_cnt_o) && !gate_en_o);
  // R9
  short_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q && !pwm_req_i && !period_start_i |=> $stable(skip_cnt_o));
endmodule

// File: tb/test_ocl_pulse_limiter.sv
module test_ocl_pulse_limiter;
  localparam int BL   = 20;
  localparam int SW   = 3;
  localparam int PLEN = 60;
  localparam int ON   = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps = 1'b0, req = 1'b0, oc = 1'b0;
  logic gate;
  logic [SW-1:0] cnt;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_on, m_b, m_lvl, m_left;

  always #2.5 clk = ~clk;

  ocl_pulse_limiter #(.BLANK_CYC(BL), .SKIP_W(SW)) i_ocl_pulse_limiter (
    .clk_i(clk), .rst_ni(rst_n), .period_start_i(ps), .pwm_req_i(req),
    .oc_flag_i(oc), .gate_en_o(gate), .skip_cnt_o(cnt)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_b = -1; m_lvl = 0; m_left = 0;
    end else if (ps) begin
      if (m_left > 0) begin m_left--; m_on = 0; m_b = -1; end
      else if (req)   begin m_on = 1; m_b = 0; end
      else            begin m_on = 0; m_b = -1; end
    end else if (m_on == 1) begin
      if (!req) begin m_on = 0; m_b = -1; end
      else if (m_b >= 0) begin
        if (m_b == BL - 1) begin
          m_b = -1;
          if (oc) begin
            m_on = 0;
            m_lvl = (m_lvl < 7) ? m_lvl + 1 : 7;
            m_left = m_lvl;
          end else if (m_lvl > 0) m_lvl--;
        end else m_b++;
      end else if (oc) m_on = 0;
    end
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({cur_req, " gate"}, int'(gate), m_on);
    chk({"R10 skip_cnt (", cur_req, ")"}, int'(cnt), m_lvl);
  end

  // one switching period; reports turn-on and gate at probe index
  task automatic run_period(int on_len, int oc_from, int oc_to, int probe,
                            output int pulse, output int probe_val);
    pulse = 0; probe_val = 0;
    for (int k = 0; k < PLEN; k++) begin
      ps  = (k == 0);
      req = (k < on_len);
      oc  = (k >= oc_from) && (k < oc_to);
      @(negedge clk);
      if (k == 0)     pulse     = int'(gate);
      if (k == probe) probe_val = int'(gate);
    end
    ps = 1'b0; req = 1'b0; oc = 1'b0;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p, g, lv, pulses;
    #12;
    chk("R1 gate in reset", int'(gate), 0);
    chk("R1 skip_cnt in reset", int'(cnt), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R2";
    for (int i = 0; i < 3; i++) begin
      run_period(ON, PLEN, PLEN, ON - 1, p, g);
      chk("R2 turn-on at strobe", p, 1);
      chk("R2 gate held while requested", g, 1);
    end

    cur_req = "R4";
    run_period(ON, 0, PLEN, BL - 1, p, g);
    chk("R3 gate held through blanking under oc", g, 1);
    chk("R5 level after first fault", int'(cnt), 1);
    cur_req = "R5";
    run_period(ON, 0, PLEN, BL + 1, p, g);
    chk("R5 one turn-on skipped", p, 0);
    run_period(ON, 0, PLEN, BL + 1, p, g);
    chk("R5 turn-on after skip", p, 1);
    chk("R4 gate off after blank-end fault", g, 0);
    chk("R5 level after second fault", int'(cnt), 2);

    cur_req = "R6";
    for (int i = 0; i < 40; i++) run_period(ON, 0, PLEN, 0, p, g);
    chk("R6 level saturated", int'(cnt), 7);
    pulses = 0;
    for (int i = 0; i < 24; i++) begin
      run_period(ON, 0, PLEN, 0, p, g);
      pulses += p;
    end
    chk("R6 turn-ons in 24 overloaded periods", pulses, 3);

    cur_req = "R7";
    for (int i = 0; i < 20; i++) begin
      lv = int'(cnt);
      run_period(ON, PLEN, PLEN, 0, p, g);
      if (p == 1) chk("R7 clean pulse lowers level", int'(cnt), (lv > 0) ? lv - 1 : 0);
    end
    chk("R7 level floor", int'(cnt), 0);

    cur_req = "R3";
    run_period(ON, 2, BL - 1, ON - 1, p, g);
    chk("R3 oc inside blanking ignored", g, 1);
    chk("R3 level unchanged at floor", int'(cnt), 0);

    cur_req = "R8";
    run_period(ON, 0, PLEN, 0, p, g);    // level 1
    run_period(ON, PLEN, PLEN, 0, p, g); // skipped
    run_period(ON, 30, 36, 32, p, g);
    chk("R8 late oc ends pulse", g, 0);
    chk("R8 late oc counted clean", int'(cnt), 0);

    cur_req = "R9";
    run_period(ON, 0, PLEN, 0, p, g);    // level 1
    run_period(ON, PLEN, PLEN, 0, p, g); // skipped
    run_period(10, 0, PLEN, 12, p, g);
    chk("R9 short pulse turned on", p, 1);
    chk("R9 short pulse ended with request", g, 0);
    chk("R9 level unchanged", int'(cnt), 1);
    run_period(ON, PLEN, PLEN, 0, p, g);
    chk("R9 no skip after short pulse", p, 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule